// File: doc/BRIEF.md
# Serial Transceiver with Switchable Oversampling

This block is a full-duplex asynchronous serial core. A transmitter and a receiver share one baud tick generator. The tick comes from a programmable divisor. Each bit period lasts either 16 or 13 ticks, selected by a single configuration bit. Running at 13 ticks per bit gives a higher line rate from the same clock and divisor.

Several frame settings are configured through static inputs: 5 to 8 data bits sent least significant bit first, no parity or even or odd parity, and a stop period of one, one and a half or two bits. The receiver reports a parity error, a framing error or a line break alongside each received byte. The transmitter can hold the line low to signal a break. Bytes enter through a valid/ready handshake and leave through another one.

Top module: `uart_os_core`

## Requirements
- R1: `cfg_div` holds N-1 for a divisor N of 1 to 16384. One oversampling tick occurs every N clock cycles, so a bit lasts N times the oversampling factor in cycles.
- R2: With `cfg_os13`=0 a bit is 16 ticks long. With `cfg_os13`=1 it is 13 ticks long.
- R3: `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits go out and come in least significant bit first. Unused upper bits of `tx_data` are ignored, and unused upper bits of `rx_data` read zero.
- R4: `cfg_par`=0 selects no parity bit, 1 selects even parity and 2 or 3 selects odd parity. The parity bit follows the last data bit.
- R5: `cfg_stop`=0 gives one stop bit. `cfg_stop`=1 gives a stop period of 24 ticks, or 20 ticks at the 13-tick setting. `cfg_stop`=2 or 3 gives two stop bits. A frame from start bit to end of stop takes (1 + data bits + parity bit) x factor + stop ticks.
- R6: While `cfg_brk_tx` is high and the transmitter is idle, `txd` is low and `tx_ready` is low. A frame already in progress completes before the line goes low. Clearing the bit returns the line high.
- R7: The receiver samples the line again at tick 8 of 16, or tick 6 of 13, after the falling edge. If the line is high at that sample, no frame is reported.
- R8: `rx_perr` is set with a byte whose received parity bit does not match the selected parity.
- R9: `rx_ferr` is set with a byte whose first stop bit was sampled low while some earlier bit of the frame was high.
- R10: A frame in which every sampled bit, including the stop bit, is low is reported with `rx_brk`=1, `rx_ferr`=0, `rx_perr`=0 and data zero. One such report is made per low period. The receiver looks for a new start only after the line has been high again.
- R11: A byte is accepted when `tx_valid` and `tx_ready` are both high, and the start bit begins on the next cycle. `rx_valid` and the received byte and flags hold until `rx_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 14 | Divisor minus one |
| cfg_os13 | input | 1 | 1: 13 ticks per bit, 0: 16 |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par | input | 2 | 0 none, 1 even, 2/3 odd |
| cfg_stop | input | 2 | 0 one, 1 one and a half, 2/3 two stop bits |
| cfg_brk_tx | input | 1 | Hold transmit line low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received byte, right aligned |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_perr | output | 1 | Parity mismatch on this byte |
| rx_ferr | output | 1 | Stop bit low on this byte |
| rx_brk | output | 1 | Whole frame was low |

## Verification
The bench measures the exact frame length in cycles for both oversampling factors and for the one-and-a-half stop period. A design that counted the half stop bit wrongly, or that kept the 16-tick length at the 13 setting, would finish frames at the wrong cycle. A short low glitch must not produce a byte. A receiver that trusted the falling edge alone would report a spurious frame. A long low line must give exactly one break report with no framing error. A receiver that rearmed while the line was still low would report a stream of frames, and one that did not separate break from framing error would raise both flags. A transmit break raised during a frame must let that frame reach the receiver intact before the line goes low, and a receiver byte must stay put while `rx_ready` is low.

// File: rtl/uart_os_core.sv
module uart_os_core #(
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_os13,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic [1:0]       cfg_stop,
  input  logic             cfg_brk_tx,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_brk
);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP, T_BRK} tx_st_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rx_st_t;

  logic [DIV_W-1:0] dcnt;
  logic             tick;
  assign tick = (dcnt >= cfg_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else        dcnt <= tick ? '0 : dcnt + 1'b1;

  // R1: the tick spacing follows the divisor
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg_div != '0) |=> (!tick || cfg_div == '0));

  logic [5:0] bit_lim, stop_lim, mid;
  logic [3:0] nbits;
  logic       par_en, par_odd;
  logic [7:0] tmask;

  assign bit_lim = cfg_os13 ? 6'd13 : 6'd16;
  assign mid     = cfg_os13 ? 6'd5 : 6'd7;
  assign nbits   = {2'b00, cfg_len} + 4'd5;
  assign par_en  = (cfg_par != 2'd0);
  assign par_odd = cfg_par[1];
  assign tmask   = 8'hFF >> (4'd8 - nbits);

  always_comb
    case (cfg_stop)
      2'd0:    stop_lim = bit_lim;
      2'd1:    stop_lim = cfg_os13 ? 6'd20 : 6'd24;
      default: stop_lim = bit_lim << 1;
    endcase

  // transmitter
  tx_st_t     ts;
  logic [5:0] tcnt;
  logic [3:0] tbit;
  logic [7:0] tsh;
  logic       tpar, tend;

  assign tend = tick && (tcnt == ((ts == T_STOP) ? stop_lim : bit_lim) - 6'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ts <= T_IDLE; tcnt <= '0; tbit <= '0; tsh <= '0; tpar <= 1'b0;
    end else begin
      case (ts)
        T_IDLE: begin
          tcnt <= '0;
          if (cfg_brk_tx) ts <= T_BRK;
          else if (tx_valid) begin
            tsh  <= tx_data & tmask;
            tpar <= (^(tx_data & tmask)) ^ par_odd;
            ts   <= T_START;
          end
        end
        T_BRK: if (!cfg_brk_tx) ts <= T_IDLE;
        default: if (tick) begin
          if (tend) begin
            tcnt <= '0;
            case (ts)
              T_START: begin ts <= T_DATA; tbit <= '0; end
              T_DATA: begin
                tsh  <= tsh >> 1;
                tbit <= tbit + 4'd1;
                if (tbit == nbits - 4'd1) ts <= par_en ? T_PAR : T_STOP;
              end
              T_PAR:   ts <= T_STOP;
              default: ts <= T_IDLE;
            endcase
          end else tcnt <= tcnt + 6'd1;
        end
      endcase
    end

  assign tx_ready = (ts == T_IDLE) && !cfg_brk_tx;

  always_comb
    case (ts)
      T_START, T_BRK: txd = 1'b0;
      T_DATA:         txd = tsh[0];
      T_PAR:          txd = tpar;
      default:        txd = 1'b1;
    endcase

  // R11: accepted byte starts its start bit on the next cycle
  a_r11_tx_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!txd && !tx_ready));

  // receiver
  rx_st_t     rst_q;
  logic [1:0] rsync;
  logic       rs, rsamp, rx_done;
  logic [5:0] rcnt;
  logic [3:0] rbit;
  logic [7:0] rsh;
  logic       racc, rzero, rperr;

  assign rs      = rsync[1];
  assign rsamp   = tick && (rcnt == ((rst_q == R_START) ? mid : bit_lim - 6'd1));
  assign rx_done = (rst_q == R_STOP) && rsamp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync <= 2'b11;
    else        rsync <= {rsync[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q <= R_IDLE; rcnt <= '0; rbit <= '0; rsh <= '0;
      racc <= 1'b0; rzero <= 1'b0; rperr <= 1'b0;
    end else begin
      case (rst_q)
        R_IDLE: begin
          rcnt <= '0;
          if (!rs) rst_q <= R_START;
        end
        R_HOLD: if (rs) rst_q <= R_IDLE;
        default: if (tick) begin
          if (rsamp) begin
            rcnt <= '0;
            case (rst_q)
              R_START:
                if (rs) rst_q <= R_IDLE;
                else begin
                  rst_q <= R_DATA; rbit <= '0; racc <= 1'b0; rzero <= 1'b1; rperr <= 1'b0;
                end
              R_DATA: begin
                rsh  <= {rs, rsh[7:1]};
                racc <= racc ^ rs;
                if (rs) rzero <= 1'b0;
                rbit <= rbit + 4'd1;
                if (rbit == nbits - 4'd1) rst_q <= par_en ? R_PAR : R_STOP;
              end
              R_PAR: begin
                rperr <= ((racc ^ rs) != par_odd);
                if (rs) rzero <= 1'b0;
                rst_q <= R_STOP;
              end
              default: rst_q <= rs ? R_IDLE : R_HOLD;
            endcase
          end else rcnt <= rcnt + 6'd1;
        end
      endcase
    end

  // R7: no frame begins while the synchronized line is high
  a_r7_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q == R_IDLE && rs) |=> (rst_q == R_IDLE));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_brk <= 1'b0;
    end else if (rx_done) begin
      rx_valid <= 1'b1;
      rx_data  <= rsh >> (4'd8 - nbits);
      rx_brk   <= rzero & !rs;
      rx_ferr  <= !rs & !rzero;
      rx_perr  <= rperr & !(rzero & !rs);
    end else if (rx_ready) rx_valid <= 1'b0;

  // R11: received byte holds until taken
  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rx_done) |=> (rx_valid && $stable(rx_data)));

  // R10: break is reported in place of a framing error
  a_r10_brk_not_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(rx_brk && rx_ferr));

endmodule

// File: tb/uart_os_core_bench.sv
`timescale 1ns/1ps
module uart_os_core_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [13:0] cfg_div = '0;
  logic cfg_os13 = 1'b0, cfg_brk_tx = 1'b0;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, tx_ready, txd, rxd, rx_valid, rx_ready = 1'b1;
  logic [7:0] rx_data;
  logic rx_perr, rx_ferr, rx_brk;
  logic lb = 1'b1, rx_drv = 1'b1;
  int n_chk = 0, n_fail = 0, got_n = 0;
  logic [7:0] got_d;
  logic got_p, got_f, got_b;

  always #4 clk = ~clk;
  assign rxd = lb ? txd : rx_drv;

  uart_os_core u_uart_os_core (.*);

  always @(negedge clk)
    if (rx_valid && rx_ready) begin
      got_n++; got_d = rx_data; got_p = rx_perr; got_f = rx_ferr; got_b = rx_brk;
    end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setcfg(input bit os13, input int len, input int par, input int stp, input int div);
    cfg_os13 = os13; cfg_len = 2'(len); cfg_par = 2'(par); cfg_stop = 2'(stp); cfg_div = 14'(div);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R6", "txd idle after reset", int'(txd), 1);
    chk(tx_ready == 1'b1, "R11", "tx_ready after reset", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R11", "rx_valid after reset", int'(rx_valid), 0);
  endtask

  task automatic t_frame(input bit os13, input int len, input int par, input int stp, input int div, input logic [7:0] d);
    int os, nb, pe, sl, T, N, cnt, n0;
    logic [7:0] m;
    setcfg(os13, len, par, stp, div);
    lb = 1'b1;
    os = os13 ? 13 : 16; nb = len + 5; pe = (par != 0) ? 1 : 0; N = div + 1;
    sl = (stp == 0) ? os : (stp == 1) ? (os13 ? 20 : 24) : 2 * os;
    T = os * (1 + nb + pe) + sl;
    m = 8'hFF >> (8 - nb);
    n0 = got_n;
    @(negedge clk); tx_data = d; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    cnt = 0;
    while (!tx_ready && cnt < 100000) begin cnt++; @(negedge clk); end
    if (N == 1) chk(cnt == T, "R1 R2 R5", "frame cycles", cnt, T);
    else chk(cnt > (T - 1) * N && cnt <= T * N, "R1 R2 R5", "frame cycles", cnt, T * N);
    repeat (20) @(negedge clk);
    chk(got_n == n0 + 1 && got_d == (d & m) && !got_p && !got_f && !got_b,
        "R3 R4", "loopback byte", int'(got_d), int'(d & m));
  endtask

  task automatic t_glitch();
    int n0 = got_n;
    setcfg(0, 3, 0, 0, 0);
    lb = 1'b0; rx_drv = 1'b1;
    @(negedge clk); rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (400) @(negedge clk);
    chk(got_n == n0 && !rx_valid, "R7", "glitch frames", got_n - n0, 0);
  endtask

  task automatic drive_bits(input logic [15:0] v, input int n, input int per);
    for (int i = 0; i < n; i++) begin
      rx_drv = v[i];
      repeat (per) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (3 * per) @(negedge clk);
  endtask

  task automatic t_perr();
    int n0 = got_n;
    setcfg(0, 3, 1, 0, 0);
    lb = 1'b0;
    drive_bits({5'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11, 16);
    chk(got_n == n0 + 1 && got_p && !got_f && got_d == 8'h01, "R8", "parity error flag", int'(got_p), 1);
  endtask

  task automatic t_ferr();
    int n0 = got_n;
    setcfg(0, 3, 0, 0, 0);
    lb = 1'b0;
    drive_bits({6'b0, 1'b0, 8'h40, 1'b0}, 10, 16);
    chk(got_n == n0 + 1 && got_f && !got_b && got_d == 8'h40, "R9", "framing error flag", int'(got_f), 1);
  endtask

  task automatic t_rxbrk();
    int n0 = got_n;
    setcfg(0, 3, 2, 0, 0);
    lb = 1'b0;
    @(negedge clk); rx_drv = 1'b0;
    repeat (30 * 16) @(negedge clk);
    chk(got_n == n0 + 1, "R10", "reports while low", got_n - n0, 1);
    rx_drv = 1'b1;
    repeat (100) @(negedge clk);
    chk(got_n == n0 + 1 && got_b && !got_f && !got_p && got_d == 8'h00, "R10", "break flag", int'(got_b), 1);
  endtask

  task automatic t_txbrk();
    int n0;
    setcfg(0, 3, 0, 0, 0);
    lb = 1'b1;
    repeat (20) @(negedge clk);
    n0 = got_n;
    @(negedge clk); tx_data = 8'h6E; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0; cfg_brk_tx = 1'b1;
    repeat (180) @(negedge clk);
    chk(got_n == n0 + 1 && got_d == 8'h6E && !got_f, "R6", "frame before break", int'(got_d), 8'h6E);
    chk(txd == 1'b0 && tx_ready == 1'b0, "R6", "line low in break", int'(txd), 0);
    repeat (250) @(negedge clk);
    chk(txd == 1'b0, "R6", "break held", int'(txd), 0);
    cfg_brk_tx = 1'b0;
    repeat (60) @(negedge clk);
    chk(txd == 1'b1 && tx_ready == 1'b1, "R6", "line back high", int'(txd), 1);
    chk(got_n == n0 + 2 && got_b, "R10", "break seen by receiver", int'(got_b), 1);
  endtask

  task automatic t_rxhold();
    setcfg(1, 3, 0, 0, 0);
    lb = 1'b1; rx_ready = 1'b0;
    @(negedge clk); tx_data = 8'hC3; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    repeat (250) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'hC3, "R11", "byte held", int'(rx_data), 8'hC3);
    repeat (100) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'hC3, "R11", "still held", int'(rx_valid), 1);
    rx_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R11", "cleared after take", int'(rx_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame(0, 3, 0, 0, 0, 8'hA5);
    t_frame(1, 3, 0, 0, 0, 8'h3C);
    t_frame(0, 0, 1, 1, 0, 8'hFB);
    t_frame(1, 2, 2, 1, 0, 8'h55);
    t_frame(0, 1, 2, 2, 0, 8'hFF);
    t_frame(1, 3, 1, 2, 2, 8'h81);
    t_glitch();
    t_perr();
    t_ferr();
    t_rxbrk();
    t_txbrk();
    t_rxhold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule